// File: doc/BRIEF.md
# NAND Bus Operation Sequencer

This block sits on the host side of an 8-bit multiplexed NAND flash bus. It carries out five operations: page read, page program, block erase, status read and device reset. A client hands over one request made of an opcode, a 28-bit flat address and a byte count. Program data then streams in, and read data streams out, each over a valid/ready pair. When the operation ends, a single-cycle response reports the outcome. The sequencer drives chip-enable, the command and address latch strobes, write-enable and read-enable. The low and high widths of the strobes come from two configuration inputs, counted in clock cycles. The sequencer puts the right command, address and data bytes on the bus and watches the open-drain ready/busy line.

Each operation is a short list of steps: command byte, address byte, data stream, busy wait, internal status read, end. A package function gives the step for each opcode and step index. After every confirm command, ready/busy passes through a two-flop synchroniser and is ignored for a fixed blanking window. Only then does the sequencer poll it. A watchdog counter ends a wait that never finishes. After a program or an erase, the sequencer reads the device status itself and reports bit 0 as the pass/fail flag. The blanking window must be at least two cycles so that it covers the synchroniser.

Top module: `nseq_top`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are 1, nand_cle and nand_ale are 0, req_ready is 1, and rsp_valid and rd_valid are 0.
- R2: A page read (req_op 0) writes command 00h with nand_cle high, then four address bytes with nand_ale high, then command 30h. The address bytes are addr[7:0], {4'h0, addr[11:8]}, addr[19:12] and addr[27:20], in that order.
- R3: After the 30h confirm, read-enable stays high until ready/busy has returned high. The read then delivers req_len bytes on rd_data, in bus order, one per read-enable pulse.
- R4: A page program (req_op 1) writes 80h, the four address bytes of R2, the req_len bytes taken from the write stream in order, and then 10h.
- R5: A block erase (req_op 2) writes 60h, then only the two row bytes addr[19:12] and addr[27:20], then D0h.
- R6: Once a program or erase has left busy, the sequencer writes 70h and gives one read-enable pulse. rsp_fail then equals bit 0 of that status byte, and the byte does not appear on rd_data.
- R7: A status read (req_op 3) writes 70h and gives one read-enable pulse, and the byte appears on rd_data. A reset (req_op 4) writes FFh and responds only after ready/busy has returned high.
- R8: Every write-enable or read-enable low pulse lasts cfg_setup_cyc+1 cycles. The strobe then stays high for at least cfg_hold_cyc+1 cycles before the next pulse. Chip-enable stays low throughout an operation.
- R9: After any confirm command (30h, 10h, D0h, FFh), no further strobe falls before BLANK_CYC cycles have passed, even if ready/busy never goes low.
- R10: If ready/busy stays low for TMO_CYC cycles of a wait, the response carries rsp_timeout=1. Chip-enable then returns high and req_ready returns to 1.
- R11: While wr_valid is 0, no write-enable pulse is given for program data. While rd_data is held unaccepted, no further read-enable pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_setup_cyc | input | CNT_W | Strobe low width minus one, in cycles |
| cfg_hold_cyc | input | CNT_W | Minimum strobe high width minus one, in cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, accepts request |
| req_op | input | 3 | 0 read, 1 program, 2 erase, 3 status, 4 reset |
| req_addr | input | 28 | Column in bits 11:0, page row in bits 27:12 |
| req_len | input | LEN_W | Data byte count for read or program (1 to 2112) |
| wr_valid | input | 1 | Program data byte offered |
| wr_ready | output | 1 | Program data byte taken |
| wr_data | input | 8 | Program data byte |
| rd_valid | output | 1 | Read byte held |
| rd_ready | input | 1 | Read byte accepted |
| rd_data | output | 8 | Read byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_fail | output | 1 | Program/erase status bit 0 |
| rsp_timeout | output | 1 | Busy wait expired |
| nand_ce_n | output | 1 | Chip-enable, active low |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write-enable, active low |
| nand_re_n | output | 1 | Read-enable, active low |
| nand_dq_out | output | 8 | Bus byte driven out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus byte from device |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
A bench-side device model records every byte latched by a write-enable rise and returns a column-derived pattern on each read-enable pulse. Reads run at two addresses and two strobe-width settings. A long busy time shows that the ready wait is honoured, and a column near the page boundary shows that the column count and ordering are right. Program and erase each run once with status bit 0 clear and once with it set, which shows that rsp_fail follows the internal status byte. A zero-length busy separates the blanking window from real polling. Stalled write and read streams, and a busy line stuck low, exercise back-pressure and the timeout exit.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_STATUS = 3'd3,
    OP_RESET  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    K_CMD, K_ADDR, K_WDATA, K_RDATA, K_RSTAT, K_ISTAT, K_WAIT, K_END
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PREP, S_LOW, S_HIGH, S_WAIT, S_DONE
  } st_e;

  typedef struct packed {
    kind_e      kind;
    logic [7:0] val;
  } step_t;

  localparam logic [7:0] C_READ  = 8'h00;
  localparam logic [7:0] C_RDGO  = 8'h30;
  localparam logic [7:0] C_PROG  = 8'h80;
  localparam logic [7:0] C_PRGO  = 8'h10;
  localparam logic [7:0] C_ERAS  = 8'h60;
  localparam logic [7:0] C_ERGO  = 8'hD0;
  localparam logic [7:0] C_STAT  = 8'h70;
  localparam logic [7:0] C_RST   = 8'hFF;

  // Address byte n of a 28-bit flat address: two column bytes, two row bytes.
  function automatic logic [7:0] addr_byte(logic [27:0] a, logic [1:0] n);
    case (n)
      2'd0:    return a[7:0];
      2'd1:    return {4'h0, a[11:8]};
      2'd2:    return a[19:12];
      default: return a[27:20];
    endcase
  endfunction

  function automatic step_t mk(kind_e k, logic [7:0] v);
    step_t s;
    s.kind = k;
    s.val  = v;
    return s;
  endfunction

  // Step list per operation, indexed by the step counter.
  function automatic step_t seq_step(op_e op, logic [3:0] idx, logic [27:0] a);
    step_t s;
    s = mk(K_END, 8'h00);
    case (op)
      OP_READ: begin
        case (idx)
          4'd0: s = mk(K_CMD, C_READ);
          4'd1, 4'd2, 4'd3, 4'd4: s = mk(K_ADDR, addr_byte(a, 2'(idx - 4'd1)));
          4'd5: s = mk(K_CMD, C_RDGO);
          4'd6: s = mk(K_WAIT, 8'h00);
          4'd7: s = mk(K_RDATA, 8'h00);
          default: s = mk(K_END, 8'h00);
        endcase
      end
      OP_PROG: begin
        case (idx)
          4'd0: s = mk(K_CMD, C_PROG);
          4'd1, 4'd2, 4'd3, 4'd4: s = mk(K_ADDR, addr_byte(a, 2'(idx - 4'd1)));
          4'd5: s = mk(K_WDATA, 8'h00);
          4'd6: s = mk(K_CMD, C_PRGO);
          4'd7: s = mk(K_WAIT, 8'h00);
          4'd8: s = mk(K_CMD, C_STAT);
          4'd9: s = mk(K_ISTAT, 8'h00);
          default: s = mk(K_END, 8'h00);
        endcase
      end
      OP_ERASE: begin
        case (idx)
          4'd0: s = mk(K_CMD, C_ERAS);
          4'd1: s = mk(K_ADDR, addr_byte(a, 2'd2));
          4'd2: s = mk(K_ADDR, addr_byte(a, 2'd3));
          4'd3: s = mk(K_CMD, C_ERGO);
          4'd4: s = mk(K_WAIT, 8'h00);
          4'd5: s = mk(K_CMD, C_STAT);
          4'd6: s = mk(K_ISTAT, 8'h00);
          default: s = mk(K_END, 8'h00);
        endcase
      end
      OP_STATUS: begin
        case (idx)
          4'd0: s = mk(K_CMD, C_STAT);
          4'd1: s = mk(K_RSTAT, 8'h00);
          default: s = mk(K_END, 8'h00);
        endcase
      end
      OP_RESET: begin
        case (idx)
          4'd0: s = mk(K_CMD, C_RST);
          4'd1: s = mk(K_WAIT, 8'h00);
          default: s = mk(K_END, 8'h00);
        endcase
      end
      default: s = mk(K_END, 8'h00);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/nseq_rb_sync.sv
module nseq_rb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_n_async,
  output logic ready_s
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= rb_n_async;
      sync_q <= meta_q;
    end
  end

  assign ready_s = sync_q;
endmodule

// File: rtl/nseq_busy_wait.sv
module nseq_busy_wait #(
  parameter int BLANK_CYC = 16,
  parameter int TMO_CYC   = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic active,
  input  logic ready_s,
  output logic done,
  output logic tmo
);
  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam logic [TMO_W-1:0] BLANK_LIM = TMO_W'(BLANK_CYC);
  localparam logic [TMO_W-1:0] TMO_LIM   = TMO_W'(TMO_CYC - 1);

  logic [TMO_W-1:0] cnt_q;
  logic             blank_over_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      blank_over_q <= 1'b0;
    end else if (arm) begin
      cnt_q        <= '0;
      blank_over_q <= 1'b0;
    end else if (active) begin
      if (cnt_q != TMO_LIM) cnt_q <= cnt_q + 1'b1;
      if (cnt_q + 1'b1 >= BLANK_LIM) blank_over_q <= 1'b1;
    end
  end

  assign done = active && blank_over_q && ready_s;
  assign tmo  = active && !done && (cnt_q == TMO_LIM);

  // R9: a wait never completes inside the blanking window
  a_r9_blank_respected: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt_q >= BLANK_LIM));

  // R10: timeout ends the wait on the next cycle
  a_r10_tmo_leaves_wait: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !active);
endmodule

// File: rtl/nseq_top.sv
module nseq_top
  import nseq_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int LEN_W     = 12,
  parameter int BLANK_CYC = 16,
  parameter int TMO_CYC   = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_setup_cyc,
  input  logic [CNT_W-1:0] cfg_hold_cyc,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [27:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             rsp_valid,
  output logic             rsp_fail,
  output logic             rsp_timeout,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_out,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_in,
  input  logic             nand_rb_n
);

  st_e              state_q;
  op_e              op_q;
  logic [27:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] bcnt_q;
  logic [3:0]       idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       dout_q;
  logic [7:0]       rd_data_q;
  logic             rd_valid_q;
  logic [7:0]       stat_q;
  logic             tmo_q;

  step_t cur;
  kind_e kind;
  logic  kind_wr, kind_rd, kind_multi, last_byte;
  logic  in_bus, byte_launch, strobe_end, rd_capture;
  logic  rb_ready_s, wait_arm, wait_done, wait_tmo;

  assign cur        = seq_step(op_q, idx_q, addr_q);
  assign kind       = cur.kind;
  assign kind_wr    = (kind == K_CMD) || (kind == K_ADDR) || (kind == K_WDATA);
  assign kind_rd    = (kind == K_RDATA) || (kind == K_RSTAT) || (kind == K_ISTAT);
  assign kind_multi = (kind == K_WDATA) || (kind == K_RDATA);
  assign last_byte  = !kind_multi || (bcnt_q == len_q - 1'b1);
  assign in_bus     = (state_q == S_LOW) || (state_q == S_HIGH);

  // Named events for the checks
  always_comb begin
    byte_launch = 1'b0;
    if (state_q == S_PREP) begin
      case (kind)
        K_CMD, K_ADDR, K_ISTAT: byte_launch = 1'b1;
        K_WDATA:                byte_launch = wr_valid;
        K_RDATA, K_RSTAT:       byte_launch = !rd_valid_q;
        default:                byte_launch = 1'b0;
      endcase
    end
  end
  assign strobe_end = (state_q == S_LOW) && (cnt_q == '0);
  assign rd_capture = strobe_end && ((kind == K_RDATA) || (kind == K_RSTAT));
  assign wait_arm   = (state_q == S_PREP) && (kind == K_WAIT);

  nseq_rb_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rb_n_async(nand_rb_n),
    .ready_s   (rb_ready_s)
  );

  nseq_busy_wait #(
    .BLANK_CYC(BLANK_CYC),
    .TMO_CYC  (TMO_CYC)
  ) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (wait_arm),
    .active (state_q == S_WAIT),
    .ready_s(rb_ready_s),
    .done   (wait_done),
    .tmo    (wait_tmo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_READ;
      addr_q  <= '0;
      len_q   <= '0;
      bcnt_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      dout_q  <= '0;
      stat_q  <= '0;
      tmo_q   <= 1'b0;
      rd_data_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          op_q    <= op_e'(req_op);
          addr_q  <= req_addr;
          len_q   <= req_len;
          idx_q   <= '0;
          bcnt_q  <= '0;
          stat_q  <= '0;
          tmo_q   <= 1'b0;
          state_q <= S_PREP;
        end
        S_PREP: begin
          if (byte_launch) begin
            if (kind == K_WDATA) dout_q <= wr_data;
            else if (kind_wr)    dout_q <= cur.val;
            cnt_q   <= cfg_setup_cyc;
            state_q <= S_LOW;
          end else if (kind == K_WAIT) begin
            state_q <= S_WAIT;
          end else if (kind == K_END) begin
            state_q <= S_DONE;
          end
        end
        S_LOW: begin
          if (strobe_end) begin
            if (kind == K_RDATA || kind == K_RSTAT) rd_data_q <= nand_dq_in;
            if (kind == K_ISTAT) stat_q <= nand_dq_in;
            cnt_q   <= cfg_hold_cyc;
            state_q <= S_HIGH;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_HIGH: begin
          if (cnt_q == '0) begin
            if (last_byte) begin
              idx_q  <= idx_q + 1'b1;
              bcnt_q <= '0;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
            state_q <= S_PREP;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_WAIT: begin
          if (wait_done) begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_PREP;
          end else if (wait_tmo) begin
            tmo_q   <= 1'b1;
            state_q <= S_DONE;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rd_valid_q <= 1'b0;
    else if (rd_capture)             rd_valid_q <= 1'b1;
    else if (rd_valid_q && rd_ready) rd_valid_q <= 1'b0;
  end

  assign req_ready   = (state_q == S_IDLE);
  assign wr_ready    = (state_q == S_PREP) && (kind == K_WDATA);
  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_data_q;
  assign rsp_valid   = (state_q == S_DONE);
  assign rsp_timeout = rsp_valid && tmo_q;
  assign rsp_fail    = rsp_valid && !tmo_q && stat_q[0] &&
                       ((op_q == OP_PROG) || (op_q == OP_ERASE));

  assign nand_ce_n   = (state_q == S_IDLE) || (state_q == S_DONE);
  assign nand_we_n   = !((state_q == S_LOW) && kind_wr);
  assign nand_re_n   = !((state_q == S_LOW) && kind_rd);
  assign nand_cle    = in_bus && (kind == K_CMD);
  assign nand_ale    = in_bus && (kind == K_ADDR);
  assign nand_dq_oe  = in_bus && kind_wr;
  assign nand_dq_out = dout_q;

  // R8: never both strobes at once
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R8: strobes only while the device is selected
  a_r8_ce_during_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  // R8: byte held steady through a write pulse
  a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out));

  // R3: page data is read only once the synchronised line says ready
  a_r3_re_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_re_n && op_q == OP_READ) |-> rb_ready_s);

  // R11: no write pulse launched without offered data
  a_r11_wr_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> nand_we_n);

  // R11: no read pulse while the held byte is unaccepted
  a_r11_rd_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (nand_re_n || op_q != OP_READ || $past(!nand_re_n)));

  // R10: a response always returns to the idle, ready state
  a_r10_idle_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (req_ready && nand_ce_n));

endmodule

// File: tb/nseq_top_tb_top.sv
module nseq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK = 6;
  localparam int TMO   = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]  cfg_setup_cyc = 4'd2, cfg_hold_cyc = 4'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [27:0] req_addr = '0;
  logic [11:0] req_len = 12'd1;
  logic        wr_valid = 1'b1;
  logic        wr_ready;
  logic [7:0]  wr_data;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [7:0]  rd_data;
  logic        rsp_valid, rsp_fail, rsp_timeout;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out, nand_dq_in;
  logic        nand_rb_n;

  nseq_top #(.CNT_W(4), .LEN_W(12), .BLANK_CYC(BLANK), .TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_setup_cyc(cfg_setup_cyc), .cfg_hold_cyc(cfg_hold_cyc),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_len(req_len), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rsp_valid(rsp_valid),
    .rsp_fail(rsp_fail), .rsp_timeout(rsp_timeout), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
    .nand_rb_n(nand_rb_n)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [11:0] c);
    return c[7:0] ^ {c[11:8], 4'h5};
  endfunction
  function automatic logic [7:0] wpat(input int i);
    return 8'(8'hC3 + i * 7);
  endfunction

  // ---------------- device model ----------------
  int   model_busy = 10;
  bit   model_fail = 1'b0;
  bit   model_stuck = 1'b0;
  int   busy_cnt = 0;
  bit   stat_mode = 1'b0;
  logic [11:0] col = '0;
  int   addr_cnt = 0;
  logic [7:0] lg_b [0:63];
  logic [1:0] lg_t [0:63];
  int   lg_n = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;
  int   we_run = 0, re_run = 0, hi_run = 0;
  bit   strobe_seen = 1'b0;
  int   tim_err = 0, re_busy_err = 0, re_falls = 0;
  bit   gap_arm = 1'b0;
  int   conf_cyc = 0, gap_meas = 0;

  assign nand_rb_n  = !(model_stuck || busy_cnt != 0);
  assign nand_dq_in = stat_mode ? (8'hE0 | {7'h0, model_fail}) : pat(col);

  always @(negedge clk) begin
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (nand_we_n && !prev_we) begin
      if (we_run != int'(cfg_setup_cyc) + 1) tim_err <= tim_err + 1;
      if (!nand_ce_n) begin
        if (lg_n < 64) begin
          lg_b[lg_n] <= nand_dq_out;
          lg_t[lg_n] <= nand_cle ? 2'd0 : (nand_ale ? 2'd1 : 2'd2);
        end
        lg_n <= lg_n + 1;
        if (nand_cle) begin
          addr_cnt  <= 0;
          stat_mode <= (nand_dq_out == 8'h70);
          if (nand_dq_out == 8'h30 || nand_dq_out == 8'h10 ||
              nand_dq_out == 8'hD0 || nand_dq_out == 8'hFF) begin
            busy_cnt <= model_busy;
            gap_arm  <= 1'b1;
            conf_cyc <= cyc;
          end
        end else if (nand_ale) begin
          if (addr_cnt == 0) col[7:0] <= nand_dq_out;
          if (addr_cnt == 1) col[11:8] <= nand_dq_out[3:0];
          addr_cnt <= addr_cnt + 1;
        end
      end
    end
    if (nand_re_n && !prev_re) begin
      if (re_run != int'(cfg_setup_cyc) + 1) tim_err <= tim_err + 1;
      if (!stat_mode) col <= col + 1'b1;
    end
    if ((!nand_we_n && prev_we) || (!nand_re_n && prev_re)) begin
      if (strobe_seen && hi_run < int'(cfg_hold_cyc) + 1) tim_err <= tim_err + 1;
      if (gap_arm) begin
        gap_meas <= cyc - conf_cyc;
        gap_arm  <= 1'b0;
      end
      strobe_seen <= 1'b1;
      hi_run <= 0;
    end else if (nand_we_n && nand_re_n) begin
      hi_run <= hi_run + 1;
    end
    if (!nand_re_n && prev_re) begin
      re_falls <= re_falls + 1;
      if (!nand_rb_n && !stat_mode) re_busy_err <= re_busy_err + 1;
    end
    if (nand_ce_n) strobe_seen <= 1'b0;
    we_run  <= nand_we_n ? 0 : we_run + 1;
    re_run  <= nand_re_n ? 0 : re_run + 1;
    prev_we <= nand_we_n;
    prev_re <= nand_re_n;
  end

  // ---------------- client side ----------------
  int wr_idx = 0;
  assign wr_data = wpat(wr_idx);
  always @(posedge clk) if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;

  logic [7:0] rcv [0:63];
  int  rcv_n = 0;
  bit  rsp_seen = 1'b0, rsp_f = 1'b0, rsp_t = 1'b0;
  int  rsp_cyc = 0;
  always @(negedge clk) begin
    if (rd_valid && rd_ready) begin
      if (rcv_n < 64) rcv[rcv_n] <= rd_data;
      rcv_n <= rcv_n + 1;
    end
    if (rsp_valid) begin
      rsp_seen <= 1'b1;
      rsp_f    <= rsp_fail;
      rsp_t    <= rsp_timeout;
      rsp_cyc  <= cyc;
    end
  end

  logic [7:0] ex_b [0:63];
  logic [1:0] ex_t [0:63];
  int ex_n = 0;
  task automatic push(input logic [1:0] t, input logic [7:0] b);
    ex_b[ex_n] = b;
    ex_t[ex_n] = t;
    ex_n++;
  endtask
  task automatic push_addr(input logic [27:0] a, input bit rows_only);
    if (!rows_only) begin
      push(2'd1, a[7:0]);
      push(2'd1, {4'h0, a[11:8]});
    end
    push(2'd1, a[19:12]);
    push(2'd1, a[27:20]);
  endtask
  task automatic check_log(input string rq);
    int bad = -1;
    for (int i = 0; i < ex_n; i++)
      if (bad < 0 && (lg_b[i] !== ex_b[i] || lg_t[i] !== ex_t[i])) bad = i;
    chk(lg_n == ex_n, rq, lg_n, ex_n);
    if (bad >= 0) chk(1'b0, rq, {lg_t[bad], lg_b[bad]}, {ex_t[bad], ex_b[bad]});
    else chk(1'b1, rq, 0, 0);
  endtask

  task automatic start_op(input logic [2:0] op, input logic [27:0] a, input int len);
    @(negedge clk);
    lg_n = 0; rcv_n = 0; ex_n = 0; rsp_seen = 1'b0; wr_idx = 0;
    tim_err = 0; re_busy_err = 0;
    req_op = op; req_addr = a; req_len = 12'(len); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input string rq);
    int n = 0;
    while (!rsp_seen && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_seen, rq, 0, 1);
  endtask

  task automatic t_reset_state;
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R1 strobes",
        {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 5'b11100);
    chk(req_ready && !rsp_valid && !rd_valid, "R1 handshake",
        {req_ready, rsp_valid, rd_valid}, 3'b100);
  endtask

  task automatic t_read(input logic [27:0] a, input int len, input logic [3:0] su,
                        input logic [3:0] ho, input int busy);
    cfg_setup_cyc = su; cfg_hold_cyc = ho; model_busy = busy;
    start_op(3'd0, a, len);
    wait_rsp("R3 read response");
    push(2'd0, 8'h00); push_addr(a, 1'b0); push(2'd0, 8'h30);
    check_log("R2 read bytes");
    chk(rcv_n == len, "R3 read count", rcv_n, len);
    for (int i = 0; i < len && i < 64; i++)
      if (rcv[i] !== pat(12'(a[11:0] + i))) chk(1'b0, "R3 read data", rcv[i], pat(12'(a[11:0] + i)));
    chk(re_busy_err == 0, "R3 no read while busy", re_busy_err, 0);
    chk(tim_err == 0, "R8 strobe widths", tim_err, 0);
    chk(gap_meas >= BLANK, "R9 blanking after confirm", gap_meas, BLANK);
  endtask

  task automatic t_prog(input logic [27:0] a, input int len, input bit f);
    model_fail = f; model_busy = 25;
    start_op(3'd1, a, len);
    wait_rsp("R4 program response");
    push(2'd0, 8'h80); push_addr(a, 1'b0);
    for (int i = 0; i < len; i++) push(2'd2, wpat(i));
    push(2'd0, 8'h10); push(2'd0, 8'h70);
    check_log("R4 program bytes");
    chk(rsp_f == f, "R6 program status bit", rsp_f, f);
    chk(rcv_n == 0, "R6 status kept internal", rcv_n, 0);
  endtask

  task automatic t_erase(input logic [27:0] a, input bit f);
    model_fail = f; model_busy = 40;
    start_op(3'd2, a, 1);
    wait_rsp("R5 erase response");
    push(2'd0, 8'h60); push_addr(a, 1'b1); push(2'd0, 8'hD0); push(2'd0, 8'h70);
    check_log("R5 erase bytes");
    chk(rsp_f == f, "R6 erase status bit", rsp_f, f);
  endtask

  task automatic t_status(input bit f);
    model_fail = f;
    start_op(3'd3, 28'h0, 1);
    wait_rsp("R7 status response");
    push(2'd0, 8'h70);
    check_log("R7 status bytes");
    chk(rcv_n == 1 && rcv[0] == (8'hE0 | {7'h0, f}), "R7 status byte", rcv[0], 8'hE0 | {7'h0, f});
  endtask

  task automatic t_reset_op;
    model_busy = 40;
    start_op(3'd4, 28'h0, 1);
    wait_rsp("R7 reset response");
    push(2'd0, 8'hFF);
    check_log("R7 reset byte");
    chk(rsp_cyc - conf_cyc >= 40, "R7 reset waits ready", rsp_cyc - conf_cyc, 40);
  endtask

  task automatic t_wr_stall;
    int n0;
    model_fail = 1'b0; model_busy = 10;
    wr_valid = 1'b0;
    start_op(3'd1, 28'h1234567, 3);
    repeat (40) @(negedge clk);
    chk(lg_n == 5, "R11 write stall", lg_n, 5);
    n0 = lg_n;
    wr_valid = 1'b1;
    wait_rsp("R11 write resume");
    chk(lg_n == n0 + 5, "R11 write resume bytes", lg_n, n0 + 5);
  endtask

  task automatic t_rd_stall;
    int f0;
    model_busy = 5;
    rd_ready = 1'b0;
    start_op(3'd0, 28'h0000040, 4);
    while (!rd_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    f0 = re_falls;
    repeat (30) @(negedge clk);
    chk(re_falls == f0, "R11 read stall", re_falls - f0, 0);
    rd_ready = 1'b1;
    wait_rsp("R11 read resume");
    chk(rcv_n == 4 && rcv[3] == pat(12'h043), "R11 read resume data", rcv[3], pat(12'h043));
  endtask

  task automatic t_timeout;
    model_stuck = 1'b1;
    start_op(3'd2, 28'h0ABCDEF, 1);
    wait_rsp("R10 timeout response");
    chk(rsp_t == 1'b1, "R10 timeout flag", rsp_t, 1);
    chk(rsp_cyc - conf_cyc >= TMO, "R10 timeout length", rsp_cyc - conf_cyc, TMO);
    @(negedge clk);
    chk(nand_ce_n && req_ready, "R10 back to idle", {nand_ce_n, req_ready}, 2'b11);
    model_stuck = 1'b0;
  endtask

  bit finished = 1'b0;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_read(28'h0ABC123, 5, 4'd2, 4'd1, 30);
    t_read(28'h13577FE, 3, 4'd0, 4'd3, 0);
    cfg_setup_cyc = 4'd1; cfg_hold_cyc = 4'd2;
    t_prog(28'h2468ACE, 6, 1'b0);
    t_prog(28'h0F0F0F1, 4, 1'b1);
    t_erase(28'hFEDC5A7, 1'b0);
    t_erase(28'h0123456, 1'b1);
    t_status(1'b1);
    t_status(1'b0);
    t_reset_op();
    t_wr_stall();
    t_rd_stall();
    t_timeout();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule